// File: doc/BRIEF.md
# Latched Select Decoder with Output Inhibit

The block turns a binary select code into a one-hot set of active-high lines, one line per code value. A small store sits in front of the decoder. While the load control is high, the store passes the select code straight through, so the lines follow the select inputs. When the load control drops, the code present at that moment is kept, and the chosen line stays high even when the select inputs move afterwards. An inhibit input forces every line low. It does not touch the stored code, so the kept selection comes back once inhibit is released.

The store comes in two forms, chosen by a parameter. The default is a level-sensitive transparent latch. The second form is an edge-triggered register that loads on each rising clock edge while the load control is high. In that form a bypass mux routes the live select code to the decoder whenever the load control is high, so the lines track the inputs with no cycle of delay and no latch is inferred. Typical uses are address decoding and routing a strobe to one of several destinations.

Top module: `sel_latch_decoder`

## Requirements
- R1: The select input is SEL_W bits wide (default 4), with bit SEL_W-1 the most significant. Code k drives output bit k high, for k from 0 to 2**SEL_W-1.
- R2: While inhibit is low, exactly one output bit is high.
- R3: While the load control is high and inhibit is low, the outputs show the decode of the current select input, with no clock edge needed.
- R4: While the load control is low, changes on the select input have no effect on the outputs.
- R5: While inhibit is high, all outputs are low, whatever the load control and select values are.
- R6: When inhibit is raised and then released with the load control held low, the code stored before inhibit reappears on the outputs.
- R7: While rst_ni is low, the stored code is cleared to zero. With the load control low after reset, output bit 0 is high.
- R8: In the register form, the stored code is the select value sampled at the last rising clock edge at which the load control was high. In the latch form, it is the select value present when the load control fell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the register form and for the checks |
| rst_ni | input | 1 | Asynchronous active-low reset, clears the stored code |
| sel_i | input | SEL_W | Select code, MSB first |
| le_i | input | 1 | Load control: high means pass and load, low means hold |
| inh_i | input | 1 | Inhibit: high forces all outputs low |
| dec_o | output | 2**SEL_W | One-hot active-high output lines |

## Verification
Every code from 0 to 15 is loaded with the load control high and then held while the select inputs are driven to the bitwise complement of that code. A swapped output bit or a store that leaks through is therefore seen at once. Inhibit is raised with the load control both low and high, and the select inputs change during inhibit, to show that the outputs go dark while the stored code stays untouched. Both store forms run side by side under the same stimulus. One sequence drops the load control between clock edges: there the latch keeps the late select value and the register keeps the value from the last edge, which tells the two forms apart. A mid-run reset shows the stored code returning to zero.

// File: rtl/latdec_pkg.sv
package latdec_pkg;
  typedef enum logic {
    STORE_LATCH = 1'b0,
    STORE_REG   = 1'b1
  } store_kind_e;

  localparam int unsigned SEL_W_DEF = 4;
endpackage

// File: rtl/latdec_store.sv
module latdec_store #(
  parameter int unsigned              W    = latdec_pkg::SEL_W_DEF,
  parameter latdec_pkg::store_kind_e  KIND = latdec_pkg::STORE_LATCH
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic [W-1:0] sel_i,
  output logic [W-1:0] code_o
);
  logic [W-1:0] held_q;

  generate
    if (KIND == latdec_pkg::STORE_LATCH) begin : g_latch
      always_latch begin
        if (!rst_ni)   held_q = '0;
        else if (le_i) held_q = sel_i;
      end
      assign code_o = held_q;
    end else begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   held_q <= '0;
        else if (le_i) held_q <= sel_i;
      end
      // bypass keeps the path transparent while loading
      assign code_o = le_i ? sel_i : held_q;
    end
  endgenerate

  AST_HOLD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && $past(!le_i)) |-> $stable(code_o)); // R4
endmodule

// File: rtl/latdec_onehot.sv
module latdec_onehot #(
  parameter int unsigned W = latdec_pkg::SEL_W_DEF,
  localparam int unsigned N = 1 << W
) (
  input  logic [W-1:0] code_i,
  input  logic         en_i,
  output logic [N-1:0] line_o
);
  generate
    for (genvar k = 0; k < N; k++) begin : g_line
      assign line_o[k] = en_i && (code_i == W'(k));
    end
  endgenerate
endmodule

// File: rtl/sel_latch_decoder.sv
module sel_latch_decoder #(
  parameter int unsigned             SEL_W      = latdec_pkg::SEL_W_DEF,
  parameter latdec_pkg::store_kind_e STORE_KIND = latdec_pkg::STORE_LATCH,
  localparam int unsigned            N          = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             le_i,
  input  logic             inh_i,
  output logic [N-1:0]     dec_o
);
  logic [SEL_W-1:0] code;

  latdec_store #(.W(SEL_W), .KIND(STORE_KIND)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .le_i   (le_i),
    .sel_i  (sel_i),
    .code_o (code)
  );

  latdec_onehot #(.W(SEL_W)) u_dec (
    .code_i (code),
    .en_i   (!inh_i),
    .line_o (dec_o)
  );

  AST_ONE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inh_i |-> ($countones(dec_o) == 1)); // R2
  AST_INH_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inh_i |-> (dec_o == '0)); // R5
  AST_TRACK_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_i && !inh_i) |-> (dec_o == (N'(1) << sel_i))); // R3
  AST_INH_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && $past(!le_i) && $fell(inh_i) && $past(!inh_i, 2) && $past(!le_i, 2))
      |-> (dec_o == $past(dec_o, 2))); // R6
endmodule

// File: tb/sel_latch_decoder_bench.sv
module sel_latch_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  sel = 4'd7;
  logic        le = 1'b0;
  logic        inh = 1'b0;
  logic [15:0] out_l, out_r;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  sel_latch_decoder u_sel_latch_decoder (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .le_i(le), .inh_i(inh), .dec_o(out_l));

  sel_latch_decoder #(.STORE_KIND(latdec_pkg::STORE_REG)) u_sel_latch_decoder_reg (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .le_i(le), .inh_i(inh), .dec_o(out_r));

  function automatic logic [15:0] hot(input logic [3:0] k);
    return 16'(1) << k;
  endfunction

  task automatic chk(input string rq, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic t_reset;
    // R7: reset state with load control low selects line 0
    #3;
    chk("R7", "latch in reset", out_l, hot(4'd0));
    chk("R7", "reg in reset", out_r, hot(4'd0));
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R7", "latch after reset", out_l, hot(4'd0));
    chk("R7", "reg after reset", out_r, hot(4'd0));
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); sel = 4'(k); le = 1'b1;
      #1;
      chk("R1", "latch follow", out_l, hot(4'(k)));   // R3
      chk("R3", "reg follow", out_r, hot(4'(k)));
      @(negedge clk); le = 1'b0;
      #1;
      chk("R2", "latch held", out_l, hot(4'(k)));
      chk("R2", "reg held", out_r, hot(4'(k)));
      sel = ~4'(k);
      #1;
      chk("R4", "latch ignores sel", out_l, hot(4'(k)));
      chk("R4", "reg ignores sel", out_r, hot(4'(k)));
    end
  endtask

  task automatic t_inhibit;
    @(negedge clk); sel = 4'd10; le = 1'b1;
    @(negedge clk); le = 1'b0; sel = 4'd3;
    #1; inh = 1'b1;
    #1;
    chk("R5", "latch dark", out_l, 16'h0);
    chk("R5", "reg dark", out_r, 16'h0);
    @(negedge clk); sel = 4'd14;
    #1;
    chk("R5", "latch dark sel moves", out_l, 16'h0);
    @(negedge clk); inh = 1'b0;
    #1;
    chk("R6", "latch restored", out_l, hot(4'd10));
    chk("R6", "reg restored", out_r, hot(4'd10));
    @(negedge clk); inh = 1'b1; le = 1'b1; sel = 4'd6;
    #1;
    chk("R5", "latch dark while loading", out_l, 16'h0);
    chk("R5", "reg dark while loading", out_r, 16'h0);
    @(negedge clk); le = 1'b0;
    @(negedge clk); inh = 1'b0;
    #1;
    chk("R6", "latch shows load under inhibit", out_l, hot(4'd6));
    chk("R6", "reg shows load under inhibit", out_r, hot(4'd6));
  endtask

  task automatic t_mid_fall;
    // R8: load control falls between edges after sel moves
    @(negedge clk); sel = 4'd5; le = 1'b1;
    @(negedge clk); sel = 4'd9;
    #1; le = 1'b0;
    #1;
    chk("R8", "latch keeps late sel", out_l, hot(4'd9));
    chk("R8", "reg keeps edge sel", out_r, hot(4'd5));
    @(negedge clk);
    chk("R8", "reg still edge sel", out_r, hot(4'd5));
  endtask

  task automatic t_rerst;
    @(negedge clk); sel = 4'd12; le = 1'b1;
    @(negedge clk); le = 1'b0; rst_n = 1'b0;
    #1;
    chk("R7", "latch cleared", out_l, hot(4'd0));
    chk("R7", "reg cleared", out_r, hot(4'd0));
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R7", "latch cleared after release", out_l, hot(4'd0));
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_inhibit();
    t_mid_fall();
    t_rerst();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule